// File: doc/BRIEF.md
# Ring Link Handshake Controller

This controller brings one device of a unidirectional ring of serial links into a verified state before any payload moves. Each device sends only to its successor and hears only from its predecessor, so the ring has at least two members. Exactly one device is strapped as the lead. Every other device is a node, and all nodes run identical logic. The controller does not serialize frames itself. It asks an attached transmitter for a flush sequence or a tagged ping through a request/acknowledge pair, and it learns of incoming pings through a one-cycle event that carries the ping's 4-bit tag.

Bring-up runs in two phases. In phase 0 the lead probes the ring with tag 0000. A node stays silent in phase 0 until that probe arrives. In phase 1 the lead sends tag 0001. A node answers the probe with its own flush and tag 0000, then waits for 0001, forwards it, and finishes. The lead finishes when 0001 returns to it. Every wait that follows a transmission has a programmable cycle-count timeout that restarts the current phase. Because of this, devices that power up in any order still converge. `link_ready_o` then stays high until reset.

Top module: `ring_hs_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first sample after it is released, `tx_req_o` and `link_ready_o` are 0.
- R2: A lead first requests a flush (`tx_kind_o`=0). After that flush is acknowledged, the very next cycle requests a ping (`tx_kind_o`=1) with `tx_tag_o`=4'b0000.
- R3: A pending request keeps `tx_req_o`, `tx_kind_o` and `tx_tag_o` unchanged until a cycle with `tx_ack_i`=1.
- R4: A lead waiting in phase 0 that samples `rx_ping_i` with tag 4'b0000 requests a ping with tag 4'b0001 on the next cycle.
- R5: After the lead's phase 0 ping is acknowledged, if no tag 0000 ping arrives, `tx_req_o` stays low for exactly `timeout_i`+1 cycles. It then rises with a flush request.
- R6: A phase 1 timeout in the lead (same `timeout_i`+1 cycle window) re-requests only the tag 0001 ping, with no flush.
- R7: A lead waiting in phase 1 that samples a tag 0001 ping raises `link_ready_o` on the next cycle.
- R8: A node in phase 0 issues no request at any time until it samples a ping with tag 4'b0000. Pings with any other tag leave it silent.
- R9: A node that has sampled tag 0000 requests a flush and then a tag 0000 ping. After it samples a tag 0001 ping, it requests a tag 0001 ping, and `link_ready_o` rises on the cycle after that ping's acknowledge.
- R10: A node in its phase 1 wait with no tag 0001 ping keeps `tx_req_o` low for `timeout_i`+1 cycles. It then repeats the flush and the tag 0000 ping.
- R11: During any wait, a ping whose tag is not the one expected for the current phase changes nothing. The wait and its timeout continue as if the ping had not arrived.
- R12: Once `link_ready_o` is 1 it stays 1 and `tx_req_o` stays 0 whatever arrives on the inputs, until `rst_ni` goes low, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lead_i | input | 1 | Role strap: 1 = lead, 0 = node (static after reset) |
| timeout_i | input | TMO_W | Wait limit; a wait expires after timeout_i+1 cycles |
| tx_req_o | output | 1 | Transmit request, held until acknowledged |
| tx_kind_o | output | 1 | 0 = flush sequence, 1 = ping frame |
| tx_tag_o | output | TAG_W | Ping tag (0 for flush) |
| tx_ack_i | input | 1 | Transmitter accepted the current request |
| rx_ping_i | input | 1 | One-cycle pulse: a valid ping was received |
| rx_tag_i | input | TAG_W | Tag of the received ping |
| link_ready_o | output | 1 | Handshake complete, sticky until reset |

## Verification
The bench goes after the timeout boundary. It counts the silent cycles after each acknowledge and expects the request on the cycle numbered `timeout_i`+2, so a timer that is off by one shows up as an early or late request. The bench also delivers pings with the wrong tag into each wait. A design that compares tags loosely would advance phases early, or would restart its timer and stretch the silent window. It probes a node with non-zero tags and long idle periods to catch a node that transmits on its own. It checks that the lead's phase 1 retry is only a tag 0001 ping, because a design that falls back to the flush would restart phase 0. Finally, it withholds acknowledges to catch requests that drop or change early, and it drives inputs after completion to catch a ready flag or transmitter that wakes up again.

// File: rtl/ring_hs_pkg.sv
package ring_hs_pkg;
  localparam int unsigned TAG_W = 4;

  localparam logic [TAG_W-1:0] TAG_P0 = 4'b0000;
  localparam logic [TAG_W-1:0] TAG_P1 = 4'b0001;

  localparam logic KIND_FLUSH = 1'b0;
  localparam logic KIND_PING  = 1'b1;

  typedef enum logic [3:0] {
    S_START,
    S_L0_FLUSH,
    S_L0_PING,
    S_L0_WAIT,
    S_L1_PING,
    S_L1_WAIT,
    S_N0_WAIT,
    S_N1_FLUSH,
    S_N1_PING,
    S_N1_WAIT,
    S_N1_FIN,
    S_DONE
  } hs_state_e;

  typedef struct packed {
    logic             req;
    logic             kind;
    logic [TAG_W-1:0] tag;
  } tx_cmd_t;
endpackage

// File: rtl/ring_hs_timer.sv
module ring_hs_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q >= limit_i);

  // each wait starts counting from zero
  a_r5_count_from_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_q == '0));
endmodule

// File: rtl/ring_hs_fsm.sv
module ring_hs_fsm
  import ring_hs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lead_i,
  input  logic             tx_ack_i,
  input  logic             rx_ping_i,
  input  logic [TAG_W-1:0] rx_tag_i,
  input  logic             tmo_i,
  output tx_cmd_t          cmd_o,
  output logic             wait_o,
  output logic             ready_o
);
  hs_state_e state_q, state_d;

  logic hit_p0, hit_p1;
  assign hit_p0 = rx_ping_i && (rx_tag_i == TAG_P0);
  assign hit_p1 = rx_ping_i && (rx_tag_i == TAG_P1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_START:    state_d = lead_i ? S_L0_FLUSH : S_N0_WAIT;
      S_L0_FLUSH: if (tx_ack_i) state_d = S_L0_PING;
      S_L0_PING:  if (tx_ack_i) state_d = S_L0_WAIT;
      S_L0_WAIT:  if (hit_p0) state_d = S_L1_PING;
                  else if (tmo_i) state_d = S_L0_FLUSH;
      S_L1_PING:  if (tx_ack_i) state_d = S_L1_WAIT;
      S_L1_WAIT:  if (hit_p1) state_d = S_DONE;
                  else if (tmo_i) state_d = S_L1_PING;
      S_N0_WAIT:  if (hit_p0) state_d = S_N1_FLUSH;
      S_N1_FLUSH: if (tx_ack_i) state_d = S_N1_PING;
      S_N1_PING:  if (tx_ack_i) state_d = S_N1_WAIT;
      S_N1_WAIT:  if (hit_p1) state_d = S_N1_FIN;
                  else if (tmo_i) state_d = S_N1_FLUSH;
      S_N1_FIN:   if (tx_ack_i) state_d = S_DONE;
      S_DONE:     state_d = S_DONE;
      default:    state_d = S_START;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_START;
    else         state_q <= state_d;
  end

  // request decode straight from state: held until the state advances on ack
  always_comb begin
    cmd_o = '{req: 1'b0, kind: KIND_FLUSH, tag: '0};
    unique case (state_q)
      S_L0_FLUSH, S_N1_FLUSH: cmd_o = '{req: 1'b1, kind: KIND_FLUSH, tag: '0};
      S_L0_PING,  S_N1_PING:  cmd_o = '{req: 1'b1, kind: KIND_PING,  tag: TAG_P0};
      S_L1_PING,  S_N1_FIN:   cmd_o = '{req: 1'b1, kind: KIND_PING,  tag: TAG_P1};
      default: ;
    endcase
  end

  assign wait_o  = (state_q == S_L0_WAIT) || (state_q == S_L1_WAIT) || (state_q == S_N1_WAIT);
  assign ready_o = (state_q == S_DONE);

  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o.req && !tx_ack_i |=> cmd_o.req && $stable(cmd_o.kind) && $stable(cmd_o.tag));

  a_r2_flush_then_ping: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o.req && tx_ack_i && (cmd_o.kind == KIND_FLUSH)
      |=> cmd_o.req && (cmd_o.kind == KIND_PING) && (cmd_o.tag == TAG_P0));

  a_r8_node_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_N0_WAIT) && !hit_p0 |=> (state_q == S_N0_WAIT) && !cmd_o.req);

  a_r7_lead_ready_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_i && $rose(ready_o) |-> $past(hit_p1));

  a_r12_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  a_r12_quiet_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !cmd_o.req);
endmodule

// File: rtl/ring_hs_ctrl.sv
module ring_hs_ctrl
  import ring_hs_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lead_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             tx_req_o,
  output logic             tx_kind_o,
  output logic [TAG_W-1:0] tx_tag_o,
  input  logic             tx_ack_i,
  input  logic             rx_ping_i,
  input  logic [TAG_W-1:0] rx_tag_i,
  output logic             link_ready_o
);
  tx_cmd_t cmd;
  logic    waiting, expired;

  ring_hs_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lead_i    (lead_i),
    .tx_ack_i  (tx_ack_i),
    .rx_ping_i (rx_ping_i),
    .rx_tag_i  (rx_tag_i),
    .tmo_i     (expired),
    .cmd_o     (cmd),
    .wait_o    (waiting),
    .ready_o   (link_ready_o)
  );

  ring_hs_timer #(.CNT_W(TMO_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (waiting),
    .limit_i   (timeout_i),
    .expired_o (expired)
  );

  assign tx_req_o  = cmd.req;
  assign tx_kind_o = cmd.kind;
  assign tx_tag_o  = cmd.tag;

  a_r5_no_tx_while_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting |-> !tx_req_o);
endmodule

// File: tb/sim_ring_hs_ctrl.sv
module sim_ring_hs_ctrl;
  localparam int TMO_W = 16;
  localparam int T     = 5;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             lead_i = 1'b1;
  logic [TMO_W-1:0] timeout_i = TMO_W'(T);
  logic             tx_req_o, tx_kind_o, link_ready_o;
  logic [3:0]       tx_tag_o;
  logic             tx_ack_i = 1'b0;
  logic             rx_ping_i = 1'b0;
  logic [3:0]       rx_tag_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ring_hs_ctrl #(.TMO_W(TMO_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .lead_i(lead_i), .timeout_i(timeout_i),
    .tx_req_o(tx_req_o), .tx_kind_o(tx_kind_o), .tx_tag_o(tx_tag_o),
    .tx_ack_i(tx_ack_i), .rx_ping_i(rx_ping_i), .rx_tag_i(rx_tag_i),
    .link_ready_o(link_ready_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit lead);
    @(negedge clk);
    rst_ni = 1'b0; lead_i = lead; tx_ack_i = 0; rx_ping_i = 0; rx_tag_i = '0;
    step();
    check(!tx_req_o && !link_ready_o, "R1 in reset", {tx_req_o, link_ready_o}, 0);
    rst_ni = 1'b1;
    check(!tx_req_o && !link_ready_o, "R1 after release", {tx_req_o, link_ready_o}, 0);
  endtask

  // wait for a request, check fields and holding, then acknowledge it
  task automatic take_req(input bit kind, input logic [3:0] tag, input string req);
    int n = 0;
    while (!tx_req_o && n < 40) begin step(); n++; end
    check(tx_req_o, req, tx_req_o, 1);
    check(tx_kind_o == kind && tx_tag_o == tag, req, {tx_kind_o, tx_tag_o}, {kind, tag});
    step();
    check(tx_req_o && tx_kind_o == kind && tx_tag_o == tag, "R3 held",
          {tx_req_o, tx_kind_o, tx_tag_o}, {1'b1, kind, tag});
    tx_ack_i = 1'b1;
    step();
    tx_ack_i = 1'b0;
  endtask

  task automatic ping(input logic [3:0] tag);
    rx_ping_i = 1'b1; rx_tag_i = tag;
    step();
    rx_ping_i = 1'b0; rx_tag_i = '0;
  endtask

  // counts wait cycles from w=start through w=T with no request, then expects one
  task automatic silent_window(input int start, input string req);
    for (int i = start; i <= T; i++) begin
      check(!tx_req_o, req, tx_req_o, 0);
      step();
    end
    check(tx_req_o, req, tx_req_o, 1);
  endtask

  task automatic t_lead();
    do_reset(1'b1);
    take_req(1'b0, 4'h0, "R2 lead flush");
    // R2: ping follows immediately after flush ack
    check(tx_req_o && tx_kind_o && tx_tag_o == 4'h0, "R2 ping after flush",
          {tx_req_o, tx_kind_o, tx_tag_o}, 6'b110000);
    take_req(1'b1, 4'h0, "R2 lead ping0");
    silent_window(0, "R5 phase0 timeout");
    check(tx_kind_o == 1'b0, "R5 retry is flush", tx_kind_o, 0);
    take_req(1'b0, 4'h0, "R5 flush again");
    take_req(1'b1, 4'h0, "R5 ping0 again");
    ping(4'h1);   // R11 wrong tag in phase 0
    check(!tx_req_o, "R11 lead p0 ignores 0001", tx_req_o, 0);
    ping(4'h0);
    check(tx_req_o && tx_kind_o && tx_tag_o == 4'h1, "R4 ping1 after tag0",
          {tx_req_o, tx_kind_o, tx_tag_o}, 6'b110001);
    take_req(1'b1, 4'h1, "R4 lead ping1");
    ping(4'h0);   // R11 wrong tag in phase 1, timer keeps running
    silent_window(1, "R11 R6 phase1 window");
    check(tx_kind_o && tx_tag_o == 4'h1, "R6 retry ping1 only", {tx_kind_o, tx_tag_o}, 5'b10001);
    take_req(1'b1, 4'h1, "R6 lead ping1 again");
    check(!link_ready_o, "R7 not ready before tag1", link_ready_o, 0);
    ping(4'h1);
    check(link_ready_o, "R7 lead ready", link_ready_o, 1);
    ping(4'h0);
    tx_ack_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      check(link_ready_o && !tx_req_o, "R12 sticky and quiet", {link_ready_o, tx_req_o}, 2);
    end
    tx_ack_i = 1'b0;
    @(negedge clk); rst_ni = 1'b0;
    #1;
    check(!link_ready_o, "R12 cleared by reset", link_ready_o, 0);
  endtask

  task automatic t_node();
    do_reset(1'b0);
    for (int i = 0; i < 3 * T; i++) begin
      check(!tx_req_o, "R8 node silent", tx_req_o, 0);
      step();
    end
    ping(4'h1);
    ping(4'h2);
    ping(4'hF);
    for (int i = 0; i < 3 * T; i++) begin
      check(!tx_req_o, "R8 node ignores other tags", tx_req_o, 0);
      step();
    end
    ping(4'h0);
    take_req(1'b0, 4'h0, "R9 node flush");
    take_req(1'b1, 4'h0, "R9 node ping0");
    silent_window(0, "R10 node timeout");
    check(tx_kind_o == 1'b0, "R10 node retry flush", tx_kind_o, 0);
    take_req(1'b0, 4'h0, "R10 node flush again");
    take_req(1'b1, 4'h0, "R10 node ping0 again");
    ping(4'h0);
    check(!tx_req_o, "R11 node p1 ignores 0000", tx_req_o, 0);
    ping(4'h1);
    take_req(1'b1, 4'h1, "R9 node ping1");
    check(link_ready_o && !tx_req_o, "R9 node ready", {link_ready_o, tx_req_o}, 2);
    ping(4'h1);
    check(link_ready_o && !tx_req_o, "R12 node stays done", {link_ready_o, tx_req_o}, 2);
  endtask

  initial begin
    #(40000 * 4);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_lead();
    t_node();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule